// File: doc/BRIEF.md
# ISDN B/D channel elastic buffer

This block sits between the line-receive side of a basic-rate S interface and the system-side frame timing of a time-division serial bus. Octets of the two bearer channels and bit pairs of the signalling channel arrive as one-cycle write strobes timed by the recovered line clock. Every system frame-start strobe returns one frame of data, with all three channels taken from the same line frame. The two frame timings may stand at any phase to each other, and the buffer absorbs the difference.

A wander detector counts line bit periods between the start of the line frame and each system frame start. It compares that count with a reference taken after reset or after the last slip. When the drift exceeds a programmable number of bit periods, the block slips. The read side jumps to the most recently completed line frame on every channel at once, the reference is re-taken, and a slip warning code is placed on a 4-bit command/indication output for two system frames. In loop-test mode the line bit timing is taken from the system bit strobe and no slip is ever raised.

Top module: `isdn_elastic_buf`

## Requirements
- R1: With steady timing at any phase of the system frame against the line frame, the k-th system frame after reset (k counted from 0, k >= 1) returns the B1 octet, the B2 octet and the D pair written in line frame k-1.
- R2: While the drift stays at or below WANDER_LIM bit periods, `slip` stays low, and each frame output is the line frame that follows the one output before it.
- R3: `slip` pulses, together with `rd_stb`, on the first system frame whose drift from the reference exceeds WANDER_LIM bit periods (default 5), in either direction. A drift of exactly WANDER_LIM does not slip.
- R4: On a slip frame, all three channel outputs come from the latest completed line frame. The following frame returns the line frame after it.
- R5: `ci_code` carries CI_SLIP (default 4'hC) on the slip frame and on the next system frame, then returns to CI_IDLE (default 4'hF). It changes only on a frame output.
- R6: While `loop_test` is high, the line timing follows `sys_bit` and `slip` never rises, whatever the drift.
- R7: After reset, `ci_code` is CI_IDLE and `rd_stb` and `slip` are low.
- R8: A slip is a single-cycle pulse. A single wander excursion produces exactly one slip, because the reference is re-taken on the next system frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_test | input | 1 | Loop-test mode: line timing from sys_bit, slips suppressed |
| line_bit | input | 1 | One strobe per line bit period |
| line_frame | input | 1 | Line frame start strobe |
| sys_bit | input | 1 | One strobe per system bit period |
| sys_frame | input | 1 | System frame start strobe, reads one frame |
| b1_wr | input | 1 | B1 octet write strobe |
| b1_in | input | 8 | B1 octet |
| b2_wr | input | 1 | B2 octet write strobe |
| b2_in | input | 8 | B2 octet |
| d_wr | input | 1 | D bit pair write strobe |
| d_in | input | 2 | D bit pair |
| rd_stb | output | 1 | Frame output valid, one cycle after sys_frame |
| b1_out | output | 8 | B1 octet for this system frame |
| b2_out | output | 8 | B2 octet for this system frame |
| d_out | output | 2 | D pair for this system frame |
| slip | output | 1 | Slip pulse, aligned with rd_stb |
| ci_code | output | 4 | Command/indication code |

## Verification
Steady timing is swept over sixteen system-frame phases across the whole line frame. Every output frame is checked against the line frame it must come from, which separates a correct lag from an off-by-one or a channel skew. Two drift runs, one with a long system period and one with a short one, move the phase by one bit per frame. These runs confirm that a drift of five passes, that a drift of six slips exactly once, that the jump lands on the newest frame, and that the warning code appears on exactly two frames. A loop-test run under the same drift confirms that no slip and no warning occur.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;
  localparam int B_W  = 8;
  localparam int D_W  = 2;
  localparam int CI_W = 4;
  typedef logic [CI_W-1:0] ci_t;
endpackage

// File: rtl/ebuf_ring.sv
// Per-channel circular store: write pointer advances on each write strobe,
// read pointer on each frame read; recentre jumps to LAG slots behind write.
module ebuf_ring #(
  parameter int W     = 8,
  parameter int DEPTH = 3,
  parameter int LAG   = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic         recentre,
  output logic [W-1:0] rd_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
  localparam logic [PW-1:0] LAG_P = PW'(LAG);
  localparam logic [PW-1:0] BACK  = PW'(DEPTH - LAG);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr, centre, idx;

  always_comb begin
    centre = (wptr >= LAG_P) ? wptr - LAG_P : wptr + BACK;
    idx    = recentre ? centre : rptr;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
    if (rd_en) rd_data <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= BACK;
    end else begin
      if (wr_en) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end
endmodule

// File: rtl/ebuf_wander.sv
// Measures the line bit phase at each system frame start against a reference.
module ebuf_wander #(
  parameter int FRAME_BITS = 48,
  parameter int WANDER_LIM = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic line_frame,
  input  logic sys_frame,
  input  logic loop_test,
  output logic slip_now
);
  localparam int PH_W = $clog2(FRAME_BITS);
  localparam int DW   = PH_W + 2;
  localparam logic signed [DW-1:0] HALF = DW'(FRAME_BITS / 2);
  localparam logic signed [DW-1:0] FULL = DW'(FRAME_BITS);
  localparam logic signed [DW-1:0] LIM  = DW'(WANDER_LIM);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_BITS - 1);

  logic [PH_W-1:0] lphase, ref_ph;
  logic            ref_ok;
  logic signed [DW-1:0] diff, mag;

  always_comb begin
    diff = $signed({2'b00, lphase}) - $signed({2'b00, ref_ph});
    if (diff >= HALF)      diff = diff - FULL;
    else if (diff < -HALF) diff = diff + FULL;
    mag = diff[DW-1] ? -diff : diff;
    slip_now = sys_frame && ref_ok && !loop_test && (mag > LIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lphase <= '0;
      ref_ph <= '0;
      ref_ok <= 1'b0;
    end else begin
      if (line_frame)    lphase <= '0;
      else if (bit_tick) lphase <= (lphase == PH_LAST) ? '0 : lphase + 1'b1;
      if (loop_test || slip_now) ref_ok <= 1'b0;
      else if (sys_frame && !ref_ok) begin
        ref_ph <= lphase;
        ref_ok <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ebuf_ci.sv
// Drives the command/indication code: slip code on the slip frame and the next.
module ebuf_ci
  import ebuf_pkg::*;
#(
  parameter ci_t CI_SLIP = 4'hC,
  parameter ci_t CI_IDLE = 4'hF
) (
  input  logic clk,
  input  logic rst,
  input  logic frame,
  input  logic slip_now,
  output ci_t  ci_code
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      ci_code <= CI_IDLE;
      pend    <= 1'b0;
    end else if (frame) begin
      if (slip_now) begin
        ci_code <= CI_SLIP;
        pend    <= 1'b1;
      end else if (pend) begin
        ci_code <= CI_SLIP;
        pend    <= 1'b0;
      end else begin
        ci_code <= CI_IDLE;
      end
    end
  end
endmodule

// File: rtl/isdn_elastic_buf.sv
module isdn_elastic_buf
  import ebuf_pkg::*;
#(
  parameter int  B_DEPTH    = 3,
  parameter int  D_PAIRS    = 2,
  parameter int  FRAME_BITS = 48,
  parameter int  WANDER_LIM = 5,
  parameter ci_t CI_SLIP    = 4'hC,
  parameter ci_t CI_IDLE    = 4'hF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           loop_test,
  input  logic           line_bit,
  input  logic           line_frame,
  input  logic           sys_bit,
  input  logic           sys_frame,
  input  logic           b1_wr,
  input  logic [B_W-1:0] b1_in,
  input  logic           b2_wr,
  input  logic [B_W-1:0] b2_in,
  input  logic           d_wr,
  input  logic [D_W-1:0] d_in,
  output logic           rd_stb,
  output logic [B_W-1:0] b1_out,
  output logic [B_W-1:0] b2_out,
  output logic [D_W-1:0] d_out,
  output logic           slip,
  output logic [CI_W-1:0] ci_code
);
  localparam int NB = 2;

  logic           bit_tick, slip_now;
  logic           b_wr [NB];
  logic [B_W-1:0] b_in [NB];
  logic [B_W-1:0] b_out[NB];

  assign bit_tick = loop_test ? sys_bit : line_bit;
  assign b_wr[0] = b1_wr;
  assign b_wr[1] = b2_wr;
  assign b_in[0] = b1_in;
  assign b_in[1] = b2_in;
  assign b1_out  = b_out[0];
  assign b2_out  = b_out[1];

  ebuf_wander #(.FRAME_BITS(FRAME_BITS), .WANDER_LIM(WANDER_LIM)) u_wander (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .line_frame(line_frame),
    .sys_frame(sys_frame), .loop_test(loop_test), .slip_now(slip_now)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bch
    ebuf_ring #(.W(B_W), .DEPTH(B_DEPTH), .LAG(1)) u_ring (
      .clk(clk), .rst(rst), .wr_en(b_wr[g]), .wr_data(b_in[g]),
      .rd_en(sys_frame), .recentre(slip_now), .rd_data(b_out[g])
    );
  end

  ebuf_ring #(.W(D_W), .DEPTH(D_PAIRS), .LAG(1)) u_dch (
    .clk(clk), .rst(rst), .wr_en(d_wr), .wr_data(d_in),
    .rd_en(sys_frame), .recentre(slip_now), .rd_data(d_out)
  );

  ebuf_ci #(.CI_SLIP(CI_SLIP), .CI_IDLE(CI_IDLE)) u_ci (
    .clk(clk), .rst(rst), .frame(sys_frame), .slip_now(slip_now), .ci_code(ci_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_stb <= 1'b0;
      slip   <= 1'b0;
    end else begin
      rd_stb <= sys_frame;
      slip   <= slip_now;
    end
  end
endmodule

// File: rtl/isdn_elastic_buf_chk.sv
module isdn_elastic_buf_chk #(
  parameter logic [3:0] CI_SLIP = 4'hC
) (
  input logic       clk,
  input logic       rst,
  input logic       loop_test,
  input logic       sys_frame,
  input logic       rd_stb,
  input logic       slip,
  input logic [3:0] ci_code
);
  AST_FRAME_ECHO: assert property (@(posedge clk) disable iff (rst) sys_frame |=> rd_stb); // R2
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (rst) !sys_frame |=> !rd_stb); // R2
  AST_SLIP_ON_FRAME: assert property (@(posedge clk) disable iff (rst) slip |-> rd_stb); // R3
  AST_SLIP_FLAGS_CI: assert property (@(posedge clk) disable iff (rst) slip |-> ci_code == CI_SLIP); // R5
  AST_CI_HOLD: assert property (@(posedge clk) disable iff (rst) !rd_stb |-> $stable(ci_code)); // R5
  AST_LOOP_NO_SLIP: assert property (@(posedge clk) disable iff (rst) (loop_test && sys_frame) |=> !slip); // R6
  AST_SINGLE_SLIP: assert property (@(posedge clk) disable iff (rst) slip |=> !slip); // R8
endmodule

bind isdn_elastic_buf isdn_elastic_buf_chk #(.CI_SLIP(CI_SLIP)) u_chk (
  .clk(clk), .rst(rst), .loop_test(loop_test), .sys_frame(sys_frame),
  .rd_stb(rd_stb), .slip(slip), .ci_code(ci_code)
);

// File: tb/isdn_elastic_buf_test.sv
module isdn_elastic_buf_test;
  localparam int FR = 192;            // cycles per line frame (48 bits x 4)
  localparam logic [3:0] SLIPC = 4'hC;
  localparam logic [3:0] IDLEC = 4'hF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loop_test = 1'b0, line_bit = 1'b0, line_frame = 1'b0;
  logic sys_bit = 1'b0, sys_frame = 1'b0;
  logic b1_wr = 1'b0, b2_wr = 1'b0, d_wr = 1'b0;
  logic [7:0] b1_in = '0, b2_in = '0;
  logic [1:0] d_in = '0;
  logic rd_stb, slip;
  logic [7:0] b1_out, b2_out;
  logic [1:0] d_out;
  logic [3:0] ci_code;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  isdn_elastic_buf uut (
    .clk(clk), .rst(rst), .loop_test(loop_test), .line_bit(line_bit),
    .line_frame(line_frame), .sys_bit(sys_bit), .sys_frame(sys_frame),
    .b1_wr(b1_wr), .b1_in(b1_in), .b2_wr(b2_wr), .b2_in(b2_in),
    .d_wr(d_wr), .d_in(d_in), .rd_stb(rd_stb), .b1_out(b1_out),
    .b2_out(b2_out), .d_out(d_out), .slip(slip), .ci_code(ci_code)
  );

  function automatic logic [7:0] fb1(int n); return 8'(n * 37 + 5); endfunction
  function automatic logic [7:0] fb2(int n); return 8'(n * 11 + 200); endfunction
  function automatic logic [1:0] fd(int n);  return 2'(n); endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // mode 0 steady, 1 drift, 2 loop test; per = system period during frames 5..12
  task automatic run(int phi, int per, int mode, int nfr, bit chk_reset);
    int cyc = 0, k = 0, nxt = phi, oc = 0, slips = 0;
    @(posedge clk); #1;
    rst = 1'b1;
    loop_test = (mode == 2);
    repeat (3) @(posedge clk);
    #1;
    if (chk_reset) begin
      chk(ci_code == IDLEC, "R7 ci", ci_code, IDLEC);
      chk(rd_stb == 1'b0, "R7 rd_stb", rd_stb, 0);
      chk(slip == 1'b0, "R7 slip", slip, 0);
    end
    rst = 1'b0;
    while (oc < nfr) begin
      int lc, n;
      @(posedge clk); #1;
      lc = cyc % FR;
      n  = cyc / FR;
      line_frame = (lc == 0);
      line_bit   = (mode != 2) && (lc % 4 == 0);
      sys_bit    = (lc % 4 == 0);
      b1_wr = (lc == 1); b1_in = fb1(n);
      b2_wr = (lc == 2); b2_in = fb2(n);
      d_wr  = (lc == 3); d_in  = fd(n);
      sys_frame = (cyc == nxt);
      if (sys_frame) begin
        k++;
        nxt += (k >= 5 && k <= 12) ? per : FR;
      end
      cyc++;
      @(negedge clk);
      if (rd_stb) begin
        if (slip) slips++;
        if (mode == 0) begin
          if (oc >= 1) begin
            chk(b1_out == fb1(oc - 1), "R1 b1", b1_out, fb1(oc - 1));
            chk(b2_out == fb2(oc - 1), "R1 b2", b2_out, fb2(oc - 1));
            chk(d_out == fd(oc - 1), "R1 d", d_out, fd(oc - 1));
          end
          chk(slip == 1'b0, "R2 steady slip", slip, 0);
          chk(ci_code == IDLEC, "R5 idle", ci_code, IDLEC);
        end else if (mode == 1) begin
          chk(slip == (oc == 10), "R3 slip timing", slip, oc == 10);
          chk(ci_code == ((oc == 10 || oc == 11) ? SLIPC : IDLEC), "R5 ci",
              ci_code, (oc == 10 || oc == 11) ? SLIPC : IDLEC);
          if (oc == 9)
            chk(b1_out == fb1(8), "R2 pre-slip b1", b1_out, fb1(8));
          if (oc == 10 || oc == 11) begin
            chk(b1_out == fb1(oc), "R4 b1", b1_out, fb1(oc));
            chk(b2_out == fb2(oc), "R4 b2", b2_out, fb2(oc));
            chk(d_out == fd(oc), "R4 d", d_out, fd(oc));
          end
        end else begin
          chk(slip == 1'b0, "R6 loop slip", slip, 0);
          chk(ci_code == IDLEC, "R6 loop ci", ci_code, IDLEC);
        end
        oc++;
      end
    end
    if (mode == 1) chk(slips == 1, "R8 slip count", slips, 1);
    if (mode == 2) chk(slips == 0, "R6 slip count", slips, 0);
    @(posedge clk); #1;
    line_frame = 0; line_bit = 0; sys_bit = 0; sys_frame = 0;
    b1_wr = 0; b2_wr = 0; d_wr = 0;
  endtask

  initial begin
    for (int p = 0; p < FR; p += 12) run(p, FR, 0, 10, p == 0);
    run(40, FR + 4, 1, 20, 1'b0);   // system period long: positive drift
    run(80, FR - 4, 1, 20, 1'b0);   // system period short: negative drift
    run(40, FR + 4, 2, 20, 1'b0);   // loop test under drift
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule